// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer that sits on a plain 32-bit register bus. The bus has a byte address, a write strobe, write data and read data. Software sets up two configuration words. The mode word turns the watchdog on and chooses what happens on a timeout. The timing word holds a reload value and a prescaler select. Neither word changes unless the write carries that word's own key pattern in its upper bits. Once enabled, a down counter steps at the prescaled rate.

If software fails to write the exact keep-alive word to the restart location in time, the counter reaches zero. The block then latches a timeout flag. It can also drive a reset pulse of selectable width, raise a level interrupt, or do both. A valid keep-alive reloads the counter and clears the flag and the interrupt.

The counter is RELOAD_W + FILL_W bits wide. A reload puts the programmed value in the upper bits and all ones in the lower FILL_W bits, so one step of the reload value is 2^FILL_W prescaled ticks. FILL_W is 12 by default. The bench sets it to 4 so that timeouts stay short.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the mode and timing words read as zero, the status flag is 0, and irq_o and rst_o are low.
- R2: A write to offset 0x0 updates the mode fields only when bits [23:12] equal 0xABC. Bit 0 is enable, bit 1 is reset-output enable, bit 2 is interrupt enable and bits [5:4] are the pulse-length code. Any other key leaves the mode word unchanged.
- R3: A write to offset 0x4 updates the timing fields only when bits [25:14] equal 0x248, which makes the word 0x00920000 plus the fields. Bits [13:2] are the 12-bit reload value and bits [1:0] are the prescaler select. Any other key leaves the timing word unchanged.
- R4: rd_data holds the register at the offset presented one clock earlier. Offset 0x0 returns the mode fields at their write positions and offset 0x4 returns the timing fields at theirs, both with zeros elsewhere. Offset 0xC returns the status flag in bit 0. Offset 0x8 reads as zero.
- R5: Prescaler select values 0, 1, 2 and 3 give one counter tick every 8, 64, 512 and 4096 clocks.
- R6: Writing exactly 0x00001999 to offset 0x8 restarts the watchdog. The restart loads the counter with {reload, all ones}, clears the prescaler, and clears the status flag and the interrupt. A write of any other value to 0x8 has no effect.
- R7: With enable set, a counter loaded with V reaches zero exactly V×D clocks after the restart write is sampled, where D is the prescale ratio. While enable is clear, the counter holds its value.
- R8: When the counter reaches zero, status bit 0 sets. If interrupt enable is set, irq_o rises in the same cycle. Both stay high until a valid restart. A counter that is already at zero raises no further event.
- R9: At the moment the counter reaches zero with reset-output enable set, rst_o goes high for 2, 4, 8 or 16 clocks for pulse-length codes 0, 1, 2 and 3. When reset-output enable is clear, rst_o stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq_o | output | 1 | Level timeout interrupt |
| rst_o | output | 1 | Timeout reset pulse |

## Verification
On every cycle the assertions check four things. A write with a bad key never changes a configuration word. The counter holds while the watchdog is disabled. The flag only rises with the counter at zero, and a restart always clears the flag and the interrupt. The interrupt is never high without the flag, and a reset pulse starts only with the flag. The exact expiry cycle for each prescale ratio, the width of each pulse code, readback formats, and the rejection of a near-miss keep-alive word are shown only by the bench's directed scenarios.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int RELOAD_W = 12;
  localparam int KEY_W    = 12;
  localparam logic [KEY_W-1:0] MODE_KEY  = 12'hABC;
  localparam logic [KEY_W-1:0] TIMER_KEY = 12'h248;
  localparam logic [31:0]      KICK_WORD = 32'h0000_1999;
  localparam logic [1:0] SEL_MODE   = 2'd0;
  localparam logic [1:0] SEL_TIMER  = 2'd1;
  localparam logic [1:0] SEL_KICK   = 2'd2;
  localparam logic [1:0] SEL_STATUS = 2'd3;

  typedef struct packed {
    logic [1:0] pulse_code;
    logic       irq_en;
    logic       rst_en;
    logic       enable;
  } mode_t;

  typedef struct packed {
    logic [RELOAD_W-1:0] reload;
    logic [1:0]          psel;
  } timer_t;
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  addr,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        status,
  output mode_t       mode_q,
  output timer_t      timer_q,
  output logic        kick,
  output logic [31:0] rd_data
);
  logic [1:0] sel;
  logic mode_ok, timer_ok;
  assign sel      = addr[3:2];
  assign mode_ok  = wr_en && sel == SEL_MODE  && wr_data[23:12] == MODE_KEY;
  assign timer_ok = wr_en && sel == SEL_TIMER && wr_data[25:14] == TIMER_KEY;
  assign kick     = wr_en && sel == SEL_KICK  && wr_data == KICK_WORD;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      timer_q <= '0;
    end else begin
      if (mode_ok) begin
        mode_q.enable     <= wr_data[0];
        mode_q.rst_en     <= wr_data[1];
        mode_q.irq_en     <= wr_data[2];
        mode_q.pulse_code <= wr_data[5:4];
      end
      if (timer_ok) begin
        timer_q.reload <= wr_data[13:2];
        timer_q.psel   <= wr_data[1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      rd_data <= '0;
      case (sel)
        SEL_MODE:   rd_data <= {26'd0, mode_q.pulse_code, 1'b0,
                                mode_q.irq_en, mode_q.rst_en, mode_q.enable};
        SEL_TIMER:  rd_data <= {18'd0, timer_q.reload, timer_q.psel};
        SEL_STATUS: rd_data <= {31'd0, status};
        default:    rd_data <= '0;
      endcase
    end
  end

  a_r2_mode_key_guard: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_MODE && wr_data[23:12] != MODE_KEY) |=> $stable(mode_q));
  a_r3_timer_key_guard: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_TIMER && wr_data[25:14] != TIMER_KEY) |=> $stable(timer_q));
endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       clear,
  input  logic [1:0] psel,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   span;
  logic [4:0]       shift;

  assign shift = 5'd3 * ({3'd0, psel} + 5'd1);
  assign span  = ((PRE_W+1)'(1) << shift) - (PRE_W+1)'(1);
  assign tick  = enable && ({1'b0, pre_q} == span);

  always_ff @(posedge clk) begin
    if (rst || clear || !enable || tick) pre_q <= '0;
    else                                 pre_q <= pre_q + 1'b1;
  end

  a_r5_no_tick_after_clear: assert property (@(posedge clk) disable iff (rst)
    clear |=> !tick);
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
#(
  parameter int FILL_W = 12,
  localparam int CNT_W = RELOAD_W + FILL_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic                tick,
  input  logic                kick,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                rst_en,
  input  logic                irq_en,
  input  logic [1:0]          pulse_code,
  output logic                status,
  output logic                irq_o,
  output logic                rst_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [4:0] pulse_q, pulse_d;
  logic hit;

  assign hit = enable && tick && !kick && cnt_q == CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '1;
    else if (kick) cnt_q <= {reload, {FILL_W{1'b1}}};
    else if (enable && tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || kick) begin
      status <= 1'b0;
      irq_o  <= 1'b0;
    end else if (hit) begin
      status <= 1'b1;
      if (irq_en) irq_o <= 1'b1;
    end
  end

  always_comb begin
    if (hit && rst_en)      pulse_d = 5'd2 << pulse_code;
    else if (pulse_q != 0)  pulse_d = pulse_q - 5'd1;
    else                    pulse_d = 5'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= '0;
      rst_o   <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
      rst_o   <= pulse_d != 5'd0;
    end
  end

  a_r7_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    (!enable && !kick) |=> $stable(cnt_q));
  a_r6_kick_clears: assert property (@(posedge clk) disable iff (rst)
    kick |=> (!status && !irq_o));
  a_r8_flag_at_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(status) |-> cnt_q == '0);
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> status);
  a_r9_pulse_with_flag: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_o) |-> status);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwdt_pkg::*;
#(
  parameter int FILL_W = 12,
  parameter int PRE_W  = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  addr,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        irq_o,
  output logic        rst_o
);
  mode_t  mode_q;
  timer_t timer_q;
  logic kick, tick, status;

  kwdt_regs u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .status(status), .mode_q(mode_q), .timer_q(timer_q), .kick(kick),
    .rd_data(rd_data)
  );

  kwdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .enable(mode_q.enable), .clear(kick),
    .psel(timer_q.psel), .tick(tick)
  );

  kwdt_counter #(.FILL_W(FILL_W)) u_cnt (
    .clk(clk), .rst(rst), .enable(mode_q.enable), .tick(tick), .kick(kick),
    .reload(timer_q.reload), .rst_en(mode_q.rst_en), .irq_en(mode_q.irq_en),
    .pulse_code(mode_q.pulse_code), .status(status), .irq_o(irq_o),
    .rst_o(rst_o)
  );
endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
  localparam int FILL = 4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] addr = '0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic irq_o, rst_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  keyed_watchdog #(.FILL_W(FILL), .PRE_W(12)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_o(irq_o), .rst_o(rst_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rd_data;
  endtask

  function automatic logic [31:0] mode_word(bit en, bit re, bit ie, logic [1:0] pc);
    return 32'h00AB_C000 | {26'd0, pc, 1'b0, ie, re, en};
  endfunction

  function automatic logic [31:0] timer_word(logic [11:0] rl, logic [1:0] ps);
    return 32'h0092_0000 | {18'd0, rl, ps};
  endfunction

  task automatic kick();
    bus_write(4'h8, 32'h0000_1999);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(4'h0, d); check("R1 mode after reset", d, 0);
    bus_read(4'h4, d); check("R1 timer after reset", d, 0);
    bus_read(4'hC, d); check("R1 status after reset", d, 0);
    check("R1 irq after reset", {31'd0, irq_o}, 0);
    check("R1 rst after reset", {31'd0, rst_o}, 0);
  endtask

  task automatic t_keys();
    logic [31:0] d;
    bus_write(4'h0, mode_word(0, 1, 1, 2'd2));
    bus_read(4'h0, d); check("R2 mode write with key", d, 32'h26);
    bus_write(4'h0, 32'h00AB_D001);
    bus_read(4'h0, d); check("R2 mode bad key ignored", d, 32'h26);
    bus_write(4'h4, timer_word(12'hA5C, 2'd3));
    bus_read(4'h4, d); check("R3 timer write with key", d, {18'd0, 12'hA5C, 2'd3});
    bus_write(4'h4, 32'h0093_0001);
    bus_read(4'h4, d); check("R3 timer bad key ignored", d, {18'd0, 12'hA5C, 2'd3});
    bus_read(4'h8, d); check("R4 restart offset reads zero", d, 0);
  endtask

  task automatic t_expire(input logic [11:0] rl, input logic [1:0] ps, input int div);
    int v;
    v = (int'(rl) << FILL) + (1 << FILL) - 1;
    bus_write(4'h0, mode_word(1, 0, 1, 2'd0));
    bus_write(4'h4, timer_word(rl, ps));
    kick();
    wait_n(v * div - 1);
    check($sformatf("R5 R7 no irq one clock early ps=%0d", ps), {31'd0, irq_o}, 0);
    wait_n(1);
    check($sformatf("R5 R7 irq at expiry ps=%0d", ps), {31'd0, irq_o}, 1);
  endtask

  task automatic t_flag_and_kick();
    logic [31:0] d;
    bus_read(4'hC, d); check("R8 status set after expiry", d, 1);
    wait_n(50);
    check("R8 irq stays high", {31'd0, irq_o}, 1);
    bus_write(4'h8, 32'h0000_1998);
    check("R6 wrong restart word ignored", {31'd0, irq_o}, 1);
    bus_read(4'hC, d); check("R6 status kept on wrong word", d, 1);
    kick();
    check("R6 restart clears irq", {31'd0, irq_o}, 0);
    bus_read(4'hC, d); check("R6 restart clears status", d, 0);
  endtask

  task automatic t_hold();
    bus_write(4'h0, mode_word(1, 0, 1, 2'd0));
    bus_write(4'h4, timer_word(12'd0, 2'd0));
    kick();
    bus_write(4'h0, mode_word(0, 0, 1, 2'd0));
    wait_n(400);
    check("R7 counter holds while disabled", {31'd0, irq_o}, 0);
    bus_write(4'h0, mode_word(1, 0, 1, 2'd0));
    wait_n(200);
    check("R7 expiry after re-enable", {31'd0, irq_o}, 1);
  endtask

  task automatic t_pulse(input logic [1:0] pc, input bit re);
    int high;
    high = 0;
    bus_write(4'h0, mode_word(1, re, 0, pc));
    bus_write(4'h4, timer_word(12'd0, 2'd0));
    kick();
    wait_n(15 * 8 - 1);
    check("R9 rst low before expiry", {31'd0, rst_o}, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (rst_o) high++;
    end
    check($sformatf("R9 pulse width code=%0d en=%0d", pc, re), high,
          re ? (2 << pc) : 0);
    check("R8 irq low when disabled", {31'd0, irq_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_keys();
    t_expire(12'd1, 2'd0, 8);
    t_flag_and_kick();
    t_expire(12'd0, 2'd1, 64);
    t_expire(12'd0, 2'd2, 512);
    t_expire(12'd0, 2'd3, 4096);
    kick();
    t_hold();
    for (int c = 0; c < 4; c++) t_pulse(c[1:0], 1'b1);
    t_pulse(2'd3, 1'b0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule